// File: doc/BRIEF.md
# Duty-Cycled Frequency-Lock Controller

This controller brings a digitally controlled oscillator onto frequency and then lets it run open-loop. It runs entirely from one slow, always-on clock. Each cycle it can read three comparator decisions about the sensed frequency voltage: above the upper edge of a dead band, below the lower edge, and above the reference level itself. From these it drives the oscillator control word and one enable shared by the loop divider and the comparator clock.

After reset the controller waits a programmable settle interval. It then runs an MSB-first binary search until the sensed value falls inside the dead band. A one-code-per-cycle search follows, which stops when the mid-point comparator changes polarity. The word is then frozen and the divider and comparators are switched off for a programmable hold interval. When that interval ends the controller settles again and corrects the word using only the one-code search. If that search runs off either end of the code range, or takes too many steps, the controller restarts the binary search and sets a sticky failure flag.

Top module: `dfll_lock_ctrl`

## Requirements
- R1: While `rst` is high, `dco_word` is 0x80 (only bit 7 set), `div_en`, `cmp_en`, `lock_done` and `lock_fail` are 0.
- R2: Once `rst` is low, `div_en` and `cmp_en` stay low for max(`settle_len`,1)-1 cycles and then rise. The first comparator evaluation falls in the cycle after they rise.
- R3: The binary search starts at 0x80. In each evaluation it ends if neither `cmp_above` nor `cmp_below` is 1, keeping the word. Otherwise it clears the trial bit if `cmp_above` is 1 and sets the next lower bit. After bit 0 has been evaluated it hands over to the one-code search.
- R4: The one-code search decrements the word when `cmp_mid` is 1 and increments it when `cmp_mid` is 0. It locks, with no step, in the first evaluation whose `cmp_mid` differs from that of the previous evaluation.
- R5: In the cycle after the locking evaluation, `lock_done` rises, `div_en` and `cmp_en` fall, and the word stays unchanged for as long as `lock_done` is high.
- R6: `lock_done` stays high for exactly max(`period_len`,1) cycles. A settle interval as in R2 follows, and then the one-code search resumes from the frozen word, with no binary phase.
- R7: If the one-code search would step below 0 or above 255, or past MAX_STEPS steps, the next cycle shows `dco_word` = 0x80 with the binary search restarted. `lock_fail` then goes to 1 and stays there until reset.
- R8: `settle_len` and `period_len` are captured only while `rst` is high. Changes made afterwards have no effect on the interval lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on controller clock |
| rst | input | 1 | Synchronous active-high reset; interval lengths captured while high |
| settle_len | input | SETTLE_W | Settle interval length in cycles |
| period_len | input | PERIOD_W | Open-loop hold interval length in cycles |
| cmp_above | input | 1 | Sensed value above the upper dead-band edge |
| cmp_below | input | 1 | Sensed value below the lower dead-band edge |
| cmp_mid | input | 1 | Sensed value above the reference level |
| dco_word | output | WORD_W | Oscillator control word |
| div_en | output | 1 | Loop divider enable |
| cmp_en | output | 1 | Comparator clock enable |
| lock_done | output | 1 | High while the word is frozen open-loop |
| lock_fail | output | 1 | Sticky flag: the one-code search ran out of range |

## Verification
The bench keeps the default parameters: an 8-bit word, a 255-step search limit and 16-bit timers. It drives a settle length of 5 and a hold length of 20 on the ports, so full lock, hold and relock cycles take tens of clock cycles, not the tens of thousands a three-minute hold would need. A behavioural sensor in the bench compares the word against a target with a dead band of 4 codes. Targets placed beyond both ends of the code range force the out-of-range fallback and the sticky flag. The full 8-bit width means every binary-search bit and both range ends are reached.

// File: rtl/dfll_ctl_pkg.sv
package dfll_ctl_pkg;

    typedef enum logic [1:0] {
        ST_SETTLE = 2'd0,
        ST_COARSE = 2'd1,
        ST_FINE   = 2'd2,
        ST_HOLD   = 2'd3
    } ctl_state_e;

    // True in the final cycle of an interval of lim cycles (lim 0 acts as 1).
    function automatic logic at_limit(input logic [31:0] cnt, input logic [31:0] lim);
        return (cnt + 32'd1) >= lim;
    endfunction

endpackage

// File: rtl/lock_timer.sv
module lock_timer
    import dfll_ctl_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else            cnt <= cnt + 1'b1;
    end

    assign last = at_limit(32'(cnt), 32'(limit));
endmodule

// File: rtl/sar_stepper.sv
module sar_stepper #(
    parameter int W     = 8,
    parameter int IDX_W = 3
) (
    input  logic [W-1:0]     word,
    input  logic [IDX_W-1:0] idx,
    input  logic             above,
    input  logic             below,
    output logic [W-1:0]     nxt_word,
    output logic [IDX_W-1:0] nxt_idx,
    output logic             done
);
    always_comb begin
        nxt_word = word;
        nxt_idx  = idx;
        done     = 1'b0;
        if (!above && !below) begin
            done = 1'b1;
        end else begin
            if (above) nxt_word[idx] = 1'b0;
            if (idx == '0) begin
                done = 1'b1;
            end else begin
                nxt_idx = idx - 1'b1;
                nxt_word[idx - 1'b1] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lin_stepper.sv
module lin_stepper #(
    parameter int W         = 8,
    parameter int STEP_W    = 8,
    parameter int MAX_STEPS = 255
) (
    input  logic [W-1:0]      word,
    input  logic              mid,
    input  logic              prev_mid,
    input  logic              first,
    input  logic [STEP_W-1:0] steps,
    output logic [W-1:0]      nxt_word,
    output logic              locked,
    output logic              fail
);
    localparam logic [STEP_W-1:0] STEP_LIM = STEP_W'(MAX_STEPS);
    localparam logic [W-1:0]      TOP_CODE = '1;

    always_comb begin
        nxt_word = word;
        locked   = !first && (mid != prev_mid);
        fail     = 1'b0;
        if (!locked) begin
            if (steps >= STEP_LIM) begin
                fail = 1'b1;
            end else if (mid) begin
                if (word == '0) fail = 1'b1;
                else            nxt_word = word - 1'b1;
            end else begin
                if (word == TOP_CODE) fail = 1'b1;
                else                  nxt_word = word + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dfll_lock_ctrl.sv
module dfll_lock_ctrl
    import dfll_ctl_pkg::*;
#(
    parameter int WORD_W    = 8,
    parameter int SETTLE_W  = 16,
    parameter int PERIOD_W  = 16,
    parameter int MAX_STEPS = 255
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SETTLE_W-1:0] settle_len,
    input  logic [PERIOD_W-1:0] period_len,
    input  logic                cmp_above,
    input  logic                cmp_below,
    input  logic                cmp_mid,
    output logic [WORD_W-1:0]   dco_word,
    output logic                div_en,
    output logic                cmp_en,
    output logic                lock_done,
    output logic                lock_fail
);
    localparam int IDX_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam int STEP_W = $clog2(MAX_STEPS + 1);
    localparam int TMR_W  = (SETTLE_W > PERIOD_W) ? SETTLE_W : PERIOD_W;
    localparam logic [WORD_W-1:0] MID_CODE = WORD_W'(1) << (WORD_W - 1);
    localparam logic [IDX_W-1:0]  TOP_IDX  = IDX_W'(WORD_W - 1);

    ctl_state_e          state;
    logic [WORD_W-1:0]   word;
    logic [IDX_W-1:0]    idx;
    logic                need_coarse;
    logic                first;
    logic                prev_mid;
    logic [STEP_W-1:0]   steps;
    logic                fail_q;
    logic [SETTLE_W-1:0] settle_q;
    logic [PERIOD_W-1:0] period_q;

    logic [TMR_W-1:0]  tmr_limit;
    logic              tmr_last;
    logic              tmr_clr;
    logic [WORD_W-1:0] sar_word;
    logic [IDX_W-1:0]  sar_idx;
    logic              sar_done;
    logic [WORD_W-1:0] lin_word;
    logic              lin_locked;
    logic              lin_fail;

    assign tmr_limit = (state == ST_HOLD) ? TMR_W'(period_q) : TMR_W'(settle_q);
    assign tmr_clr   = (state == ST_COARSE) || (state == ST_FINE) || tmr_last;

    lock_timer #(.W(TMR_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (tmr_clr),
        .limit (tmr_limit),
        .last  (tmr_last)
    );

    sar_stepper #(.W(WORD_W), .IDX_W(IDX_W)) u_sar (
        .word     (word),
        .idx      (idx),
        .above    (cmp_above),
        .below    (cmp_below),
        .nxt_word (sar_word),
        .nxt_idx  (sar_idx),
        .done     (sar_done)
    );

    lin_stepper #(.W(WORD_W), .STEP_W(STEP_W), .MAX_STEPS(MAX_STEPS)) u_lin (
        .word     (word),
        .mid      (cmp_mid),
        .prev_mid (prev_mid),
        .first    (first),
        .steps    (steps),
        .nxt_word (lin_word),
        .locked   (lin_locked),
        .fail     (lin_fail)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_SETTLE;
            word        <= MID_CODE;
            idx         <= TOP_IDX;
            need_coarse <= 1'b1;
            first       <= 1'b1;
            prev_mid    <= 1'b0;
            steps       <= '0;
            fail_q      <= 1'b0;
            settle_q    <= settle_len;
            period_q    <= period_len;
        end else begin
            case (state)
                ST_SETTLE: begin
                    if (tmr_last) begin
                        first <= 1'b1;
                        steps <= '0;
                        if (need_coarse) begin
                            state <= ST_COARSE;
                            word  <= MID_CODE;
                            idx   <= TOP_IDX;
                        end else begin
                            state <= ST_FINE;
                        end
                    end
                end
                ST_COARSE: begin
                    word <= sar_word;
                    idx  <= sar_idx;
                    if (sar_done) begin
                        state <= ST_FINE;
                        first <= 1'b1;
                        steps <= '0;
                    end
                end
                ST_FINE: begin
                    if (lin_locked) begin
                        state       <= ST_HOLD;
                        need_coarse <= 1'b0;
                    end else if (lin_fail) begin
                        state  <= ST_COARSE;
                        word   <= MID_CODE;
                        idx    <= TOP_IDX;
                        fail_q <= 1'b1;
                    end else begin
                        word     <= lin_word;
                        first    <= 1'b0;
                        prev_mid <= cmp_mid;
                        steps    <= steps + 1'b1;
                    end
                end
                default: begin
                    if (tmr_last) state <= ST_SETTLE;
                end
            endcase
        end
    end

    logic loop_on;
    assign loop_on   = !rst && ((state == ST_COARSE) || (state == ST_FINE) ||
                                ((state == ST_SETTLE) && tmr_last));
    assign div_en    = loop_on;
    assign cmp_en    = loop_on;
    assign lock_done = (state == ST_HOLD);
    assign lock_fail = fail_q;
    assign dco_word  = word;

    // R5: word frozen while open-loop
    p_word_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        (lock_done && $past(lock_done)) |-> $stable(dco_word));

    // R5: divider and comparators off while open-loop
    p_gates_off_r5: assert property (@(posedge clk) disable iff (rst)
        lock_done |-> (!div_en && !cmp_en));

    // R4: one-code search moves the word by at most one code per cycle
    p_fine_step_r4: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_FINE) && ($past(state) == ST_FINE)) |->
            ($stable(dco_word) || (dco_word == $past(dco_word) + 1'b1) ||
             (dco_word == $past(dco_word) - 1'b1)));

    // R7: failure flag is sticky
    p_fail_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        $past(lock_fail) |-> lock_fail);

    // R6: relock skips the binary phase
    p_relock_fine_only_r6: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_SETTLE) && tmr_last && !need_coarse) |=> (state == ST_FINE));

    // R2: enables rise only out of the settle interval
    p_enable_after_settle_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(div_en) |-> (state == ST_SETTLE));
endmodule

// File: tb/dfll_lock_ctrl_test.sv
module dfll_lock_ctrl_test;
    localparam int DZ = 4;
    localparam int NVEC = 6;
    localparam int VEC_T [NVEC] = '{10, 100, 128, 200, 37, 3};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] settle_len = 16'd5;
    logic [15:0] period_len = 16'd20;
    logic        cmp_above, cmp_below, cmp_mid;
    logic [7:0]  dco_word;
    logic        div_en, cmp_en, lock_done, lock_fail;
    int          target = 10;
    int          errs = 0;
    int          checks = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    // Behavioural sensor: word compared against a target with a dead band.
    assign cmp_above = (int'(dco_word) > target + DZ);
    assign cmp_below = (int'(dco_word) + DZ < target);
    assign cmp_mid   = (int'(dco_word) > target);

    dfll_lock_ctrl uut (
        .clk(clk), .rst(rst), .settle_len(settle_len), .period_len(period_len),
        .cmp_above(cmp_above), .cmp_below(cmp_below), .cmp_mid(cmp_mid),
        .dco_word(dco_word), .div_en(div_en), .cmp_en(cmp_en),
        .lock_done(lock_done), .lock_fail(lock_fail)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_lock(input int t);
        int w = 0;
        bit stop = 1'b0;
        for (int b = 7; b >= 0; b--) begin
            if (!stop) begin
                int tr = w | (1 << b);
                if (!(tr > t + DZ) && !(tr + DZ < t)) begin
                    w = tr;
                    stop = 1'b1;
                end else if (!(tr > t + DZ)) begin
                    w = tr;
                end
            end
        end
        if (w > t) return t;
        return t + 1;
    endfunction

    task automatic do_reset(input int s, input int p);
        @(negedge clk);
        rst = 1'b1;
        settle_len = 16'(s);
        period_len = 16'(p);
        repeat (3) @(negedge clk);
        #1;
        chk(dco_word == 8'h80, "R1 reset word", dco_word, 128);
        chk(!div_en && !cmp_en && !lock_done && !lock_fail, "R1 reset outputs",
            {div_en, cmp_en, lock_done, lock_fail}, 0);
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    task automatic count_settle(output int n);
        n = 0;
        while (!div_en && n < 1000) begin
            @(negedge clk); #1;
            n++;
        end
    endtask

    task automatic wait_lock(output bit ok);
        int n = 0;
        while (!lock_done && n < 5000) begin
            @(negedge clk); #1;
            n++;
        end
        ok = lock_done;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL R5 watchdog: actual lock_done 0 expected 1");
            $display("  Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int n;
        bit ok;
        int trace [11];
        int maxd;
        int prevw;

        // Directed: settle, binary trace, fine trace, hold, relock, R8.
        target = 10;
        do_reset(5, 20);
        settle_len = 16'd60;   // R8: ignored after reset
        period_len = 16'd3;
        count_settle(n);
        chk(n == 4, "R2 settle cycles", n, 4);
        chk(cmp_en == 1'b1, "R2 comparator enable", cmp_en, 1);
        trace = '{128, 128, 64, 32, 16, 8, 8, 9, 10, 11, 11};
        for (int i = 0; i < 11; i++) begin
            if (i > 0) begin @(negedge clk); #1; end
            chk(int'(dco_word) == trace[i], (i < 6) ? "R3 binary trace" : "R4 fine trace",
                dco_word, trace[i]);
            chk(lock_done == (i == 10), "R5 lock_done timing", lock_done, (i == 10));
        end
        chk(!div_en && !cmp_en, "R5 enables off at lock", div_en, 0);
        n = 0;
        while (lock_done && n < 1000) begin
            @(negedge clk); #1;
            n++;
        end
        chk(n == 20, "R6 R8 hold length", n, 20);
        target = 14;
        count_settle(n);
        chk(n == 4, "R6 R8 relock settle", n, 4);
        maxd = 0;
        prevw = dco_word;
        n = 0;
        while (!lock_done && n < 1000) begin
            @(negedge clk); #1;
            n++;
            if (int'(dco_word) - prevw > maxd) maxd = int'(dco_word) - prevw;
            if (prevw - int'(dco_word) > maxd) maxd = prevw - int'(dco_word);
            prevw = dco_word;
        end
        chk(maxd <= 1, "R6 relock fine only", maxd, 1);
        chk(dco_word == 8'd15, "R6 relock word", dco_word, 15);

        // settle_len of 0 behaves as 1
        do_reset(0, 20);
        chk(div_en == 1'b1, "R2 zero settle", div_en, 1);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            target = VEC_T[v];
            do_reset(5, 20);
            wait_lock(ok);
            chk(ok, "R3 R4 lock reached", ok, 1);
            chk(int'(dco_word) == exp_lock(VEC_T[v]), "R3 R4 lock word",
                dco_word, exp_lock(VEC_T[v]));
            chk(!lock_fail, "R7 no fail on good lock", lock_fail, 0);
            @(negedge clk); #1;
            chk(int'(dco_word) == exp_lock(VEC_T[v]), "R5 frozen word",
                dco_word, exp_lock(VEC_T[v]));
        end

        // Fallback from the top of the range
        target = 300;
        do_reset(5, 20);
        n = 0;
        prevw = 0;
        while (!lock_fail && n < 2000) begin
            prevw = dco_word;
            @(negedge clk); #1;
            n++;
        end
        chk(lock_fail == 1'b1, "R7 fail raised high end", lock_fail, 1);
        chk(prevw == 255, "R7 word at top before fail", prevw, 255);
        chk(dco_word == 8'h80, "R7 restart word", dco_word, 128);
        target = 60;
        wait_lock(ok);
        chk(int'(dco_word) == exp_lock(60), "R7 lock after fallback", dco_word, exp_lock(60));
        chk(lock_fail == 1'b1, "R7 sticky fail", lock_fail, 1);

        // Fallback from the bottom of the range
        target = -10;
        do_reset(5, 20);
        n = 0;
        while (!lock_fail && n < 2000) begin
            @(negedge clk); #1;
            n++;
        end
        chk(lock_fail == 1'b1, "R7 fail raised low end", lock_fail, 1);
        chk(dco_word == 8'h80, "R7 restart word low end", dco_word, 128);
        target = 10;
        do_reset(5, 20);
        chk(!lock_fail, "R1 reset clears fail", lock_fail, 0);

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule